// File: doc/BRIEF.md
# Cartridge Program-ROM Outer Bank Register Block

This block sits on a retro console's CPU cartridge bus and turns writes into a small register window into the upper program-ROM address lines. Those lines, A21 down to A15, pick which 32 KB bank of a large ROM appears in the CPU's $8000 window. The block also drives one general-purpose output pin. It returns one external input pin when the CPU reads a status location.

A mode register controls two behaviours. It can force the two lowest bank bits high, which takes effect as soon as the mode register is written. It can also make later writes to the other three registers store their two lowest data bits exchanged. The bus is sampled with a fast system clock, and write data is taken on the falling edge of M2.

Top module: `prg_bank_mapper`

## Requirements
- R1: After reset every stored bit is 0, so `prg_hi` reads 7'h03 (bits 1:0 forced high), `gpio_out` is 0 and `rd_oe` is 0.
- R2: A write is taken only on an M2 falling edge with `romsel_n`=1, A14=1, A13=0, A10=0 and `cpu_rw`=0. With A12=1, {A9,A8} selects the low bank register (00), the pin register (01), the high bank register (10) or the mode register (11). Without such a write, no output changes.
- R3: `prg_hi[6:4]` (A21..A19) equal bits 2:0 of the high bank register.
- R4: Mode data bit 2 (full mode) set gives `prg_hi[3:0]` = low bank register bits 3:0. When it is clear, bits 3:2 come from that register and bits 1:0 are 1. A mode write changes `prg_hi` with no further write.
- R5: With mode data bit 0 (swap) set, later writes to the low bank, pin and high bank registers store data bits 0 and 1 exchanged. A mode write leaves the stored values of those three registers unchanged.
- R6: `gpio_out` equals bit 0 of the stored pin register.
- R7: A read with A12=1, A9=0, A8=1, `romsel_n`=1, A14=1, A13=0 and M2 high drives `rd_oe`=1 and `rd_d2`=`ext_in`, whatever the mode register holds; A10 is ignored on reads.
- R8: Reads of any other location, or with M2 low, keep `rd_oe`=0.
- R9: Writes with A10=1, with `romsel_n`=0, with A12=0 (the four inert locations) or with `cpu_rw`=1 change neither `prg_hi` nor `gpio_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Active-low reset (power-up state) |
| cpu_a14 | input | 1 | CPU address bit 14 |
| cpu_a13 | input | 1 | CPU address bit 13 |
| cpu_a12 | input | 1 | CPU address bit 12 |
| cpu_a10 | input | 1 | CPU address bit 10 (must be 0 for writes) |
| cpu_a9 | input | 1 | CPU address bit 9 |
| cpu_a8 | input | 1 | CPU address bit 8 |
| cpu_rw | input | 1 | 1 = read, 0 = write |
| romsel_n | input | 1 | ROM select, active low |
| m2 | input | 1 | CPU phase-2 clock |
| cpu_d | input | 4 | CPU data bits 3..0 |
| ext_in | input | 1 | External input pin returned on reads |
| prg_hi | output | 7 | Program-ROM address A21..A15 |
| gpio_out | output | 1 | General-purpose output pin |
| rd_d2 | output | 1 | Read data bit 2 |
| rd_oe | output | 1 | Output enable for read data bit 2 |

## Verification
The bank path is driven with a fixed write sequence whose resulting bank numbers (19, 17, 17, 18, 34) are known in advance. This sequence separates the forced-ones mode from the full mode and separates swapped from unswapped storage. It also shows that a mode write moves the bank at once but leaves stored bits alone. A second sequence on the pin register shows that the exchange applies only to writes made after the swap bit is set. Near-miss addresses (A10 high, ROM select low, the inert locations, a read cycle) confirm that the decode keeps register state untouched. Reads with both levels of the external pin, in both modes, show that the returned bit follows the pin and that other locations leave the bus undriven.

// File: rtl/prg_map_pkg.sv
package prg_map_pkg;
    parameter int LO_W    = 4;   // outer bank bits A18..A15
    parameter int HI_W    = 3;   // outer bank bits A21..A19
    parameter int DATA_W  = 4;   // data bits seen by the block
    parameter int GP_W    = 2;   // stored pin register bits
    parameter int FORCE_W = 2;   // low bank bits forced high in reduced mode
    localparam int BANK_W = LO_W + HI_W;

    // register index formed from {A12, A9, A8}
    localparam logic [2:0] IDX_LO   = 3'b100;
    localparam logic [2:0] IDX_PIN  = 3'b101;
    localparam logic [2:0] IDX_HI   = 3'b110;
    localparam logic [2:0] IDX_MODE = 3'b111;

    // mode data bit positions
    localparam int MODE_FULL_BIT = 2;
    localparam int MODE_SWAP_BIT = 0;

    typedef struct packed {
        logic [LO_W-1:0] lo;
        logic [HI_W-1:0] hi;
        logic [GP_W-1:0] pin;
        logic            full;
        logic            swap;
    } bank_state_t;

    function automatic logic [DATA_W-1:0] swap_low_pair(input logic [DATA_W-1:0] v);
        logic [DATA_W-1:0] r;
        r    = v;
        r[0] = v[1];
        r[1] = v[0];
        return r;
    endfunction
endpackage

// File: rtl/m2_fall_det.sv
module m2_fall_det (
    input  logic clk,
    input  logic rst_n,
    input  logic m2,
    output logic fall
);
    logic m2_d, m2_q;

    always_comb begin
        m2_d = m2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) m2_q <= 1'b0;
        else        m2_q <= m2_d;
    end

    assign fall = m2_q & ~m2;
endmodule

// File: rtl/reg_addr_decode.sv
module reg_addr_decode (
    input  logic       cpu_a14,
    input  logic       cpu_a13,
    input  logic       cpu_a12,
    input  logic       cpu_a10,
    input  logic       cpu_a9,
    input  logic       cpu_a8,
    input  logic       cpu_rw,
    input  logic       romsel_n,
    input  logic       m2,
    output logic [2:0] idx,
    output logic       wr_ok,
    output logic       rd_pin
);
    import prg_map_pkg::*;
    logic window;

    always_comb begin
        window = romsel_n & cpu_a14 & ~cpu_a13;
        idx    = {cpu_a12, cpu_a9, cpu_a8};
        wr_ok  = window & ~cpu_a10 & ~cpu_rw;
        rd_pin = window & cpu_rw & m2 & (idx == IDX_PIN);
    end
endmodule

// File: rtl/bank_reg_file.sv
module bank_reg_file
    import prg_map_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [2:0]        idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [BANK_W-1:0] prg_hi,
    output logic              gpio_out
);
    bank_state_t st_d, st_q;
    logic [DATA_W-1:0] stored_v;

    always_comb begin
        st_d     = st_q;
        stored_v = st_q.swap ? swap_low_pair(wdata) : wdata;
        if (wr_stb) begin
            case (idx)
                IDX_LO:   st_d.lo  = stored_v[LO_W-1:0];
                IDX_PIN:  st_d.pin = stored_v[GP_W-1:0];
                IDX_HI:   st_d.hi  = stored_v[HI_W-1:0];
                IDX_MODE: begin
                    st_d.full = wdata[MODE_FULL_BIT];
                    st_d.swap = wdata[MODE_SWAP_BIT];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    logic [LO_W-1:0] lo_eff;
    generate
        if (LO_W > FORCE_W) begin : g_split
            always_comb lo_eff = st_q.full ? st_q.lo
                                           : {st_q.lo[LO_W-1:FORCE_W], {FORCE_W{1'b1}}};
        end else begin : g_all
            always_comb lo_eff = st_q.full ? st_q.lo : {LO_W{1'b1}};
        end
    endgenerate

    assign prg_hi   = {st_q.hi, lo_eff};
    assign gpio_out = st_q.pin[0];
endmodule

// File: rtl/prg_bank_mapper.sv
module prg_bank_mapper (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cpu_a14,
    input  logic       cpu_a13,
    input  logic       cpu_a12,
    input  logic       cpu_a10,
    input  logic       cpu_a9,
    input  logic       cpu_a8,
    input  logic       cpu_rw,
    input  logic       romsel_n,
    input  logic       m2,
    input  logic [3:0] cpu_d,
    input  logic       ext_in,
    output logic [6:0] prg_hi,
    output logic       gpio_out,
    output logic       rd_d2,
    output logic       rd_oe
);
    logic       m2_fall;
    logic [2:0] idx;
    logic       wr_ok, rd_pin;

    m2_fall_det u_fall (
        .clk (clk), .rst_n (rst_n), .m2 (m2), .fall (m2_fall)
    );

    reg_addr_decode u_dec (
        .cpu_a14 (cpu_a14), .cpu_a13 (cpu_a13), .cpu_a12 (cpu_a12),
        .cpu_a10 (cpu_a10), .cpu_a9 (cpu_a9), .cpu_a8 (cpu_a8),
        .cpu_rw (cpu_rw), .romsel_n (romsel_n), .m2 (m2),
        .idx (idx), .wr_ok (wr_ok), .rd_pin (rd_pin)
    );

    bank_reg_file u_regs (
        .clk (clk), .rst_n (rst_n), .wr_stb (m2_fall & wr_ok),
        .idx (idx), .wdata (cpu_d), .prg_hi (prg_hi), .gpio_out (gpio_out)
    );

    assign rd_oe = rd_pin;
    assign rd_d2 = rd_pin & ext_in;
endmodule

// File: rtl/prg_bank_mapper_chk.sv
module prg_bank_mapper_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cpu_a14,
    input logic       cpu_a13,
    input logic       cpu_a10,
    input logic       cpu_rw,
    input logic       romsel_n,
    input logic       m2,
    input logic       ext_in,
    input logic [6:0] prg_hi,
    input logic       gpio_out,
    input logic       rd_d2,
    input logic       rd_oe
);
    logic m2_seen;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) m2_seen <= 1'b0;
        else        m2_seen <= m2;
    end
    wire edge_now = m2_seen & ~m2;

    // R1
    reset_bank_chk: assert property (@(posedge clk) $rose(rst_n) |-> (prg_hi == 7'h03 && !gpio_out));

    // R2
    quiet_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !edge_now |=> ($stable(prg_hi) && $stable(gpio_out)));

    // R9
    a10_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_now && (cpu_a10 || !romsel_n || cpu_rw)) |=> ($stable(prg_hi) && $stable(gpio_out)));

    // R8
    oe_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_oe |-> (m2 && cpu_rw && romsel_n && cpu_a14 && !cpu_a13));

    // R7
    pin_echo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_oe |-> (rd_d2 == ext_in));
endmodule

bind prg_bank_mapper prg_bank_mapper_chk chk_i (
    .clk (clk), .rst_n (rst_n), .cpu_a14 (cpu_a14), .cpu_a13 (cpu_a13),
    .cpu_a10 (cpu_a10), .cpu_rw (cpu_rw), .romsel_n (romsel_n), .m2 (m2),
    .ext_in (ext_in), .prg_hi (prg_hi), .gpio_out (gpio_out),
    .rd_d2 (rd_d2), .rd_oe (rd_oe)
);

// File: tb/prg_bank_mapper_tb_top.sv
module prg_bank_mapper_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cpu_a14 = 0, cpu_a13 = 0, cpu_a12 = 0, cpu_a10 = 0, cpu_a9 = 0, cpu_a8 = 0;
    logic       cpu_rw = 1'b1, romsel_n = 1'b0, m2 = 1'b0, ext_in = 1'b0;
    logic [3:0] cpu_d = '0;
    logic [6:0] prg_hi;
    logic       gpio_out, rd_d2, rd_oe;

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;   // 250 MHz

    prg_bank_mapper dut_i (
        .clk (clk), .rst_n (rst_n), .cpu_a14 (cpu_a14), .cpu_a13 (cpu_a13),
        .cpu_a12 (cpu_a12), .cpu_a10 (cpu_a10), .cpu_a9 (cpu_a9), .cpu_a8 (cpu_a8),
        .cpu_rw (cpu_rw), .romsel_n (romsel_n), .m2 (m2), .cpu_d (cpu_d),
        .ext_in (ext_in), .prg_hi (prg_hi), .gpio_out (gpio_out),
        .rd_d2 (rd_d2), .rd_oe (rd_oe)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic put_addr(input logic [15:0] a);
        romsel_n = ~a[15];
        cpu_a14 = a[14]; cpu_a13 = a[13]; cpu_a12 = a[12];
        cpu_a10 = a[10]; cpu_a9 = a[9]; cpu_a8 = a[8];
    endtask

    task automatic bus_cycle(input logic [15:0] a, input logic [3:0] d, input logic rw);
        @(negedge clk);
        put_addr(a); cpu_d = d; cpu_rw = rw; m2 = 1'b1;
        repeat (2) @(negedge clk);
        m2 = 1'b0;
        repeat (3) @(negedge clk);
        cpu_rw = 1'b1;
    endtask

    task automatic wr(input logic [15:0] a, input logic [3:0] d);
        bus_cycle(a, d, 1'b0);
    endtask

    task automatic rd_sample(input logic [15:0] a, output logic oe, output logic d2);
        @(negedge clk);
        put_addr(a); cpu_rw = 1'b1; m2 = 1'b1;
        @(negedge clk);
        oe = rd_oe; d2 = rd_d2;
        m2 = 1'b0;
        @(negedge clk);
    endtask

    task automatic do_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset;
        do_reset();
        check("R1 prg_hi", prg_hi, 3);
        check("R1 gpio", gpio_out, 0);
        check("R1 oe", rd_oe, 0);
    endtask

    task automatic t_bank_sequence;
        do_reset();
        wr(16'h5300, 4'h0);
        wr(16'h5200, 4'h1);
        wr(16'h5000, 4'h1);
        check("R4 reduced mode bank", prg_hi, 19);
        check("R3 high bits", prg_hi[6:4], 1);
        wr(16'h5300, 4'h4);
        check("R4 full mode immediate", prg_hi, 17);
        wr(16'h5300, 4'h5);
        check("R5 mode write keeps stored", prg_hi, 17);
        wr(16'h5000, 4'h1);
        check("R5 swapped low write", prg_hi, 18);
        wr(16'h5200, 4'h1);
        check("R5 swapped high write", prg_hi, 34);
    endtask

    task automatic t_full_bits;
        do_reset();
        wr(16'h5300, 4'h4);
        wr(16'h5000, 4'hA);
        wr(16'h5200, 4'h4);
        check("R4 full low bits", prg_hi[3:0], 10);
        check("R3 A21 set", prg_hi, 7'h4A);
        wr(16'h5300, 4'h0);
        check("R4 reduced forces ones", prg_hi, 7'h4B);
    endtask

    task automatic t_pin;
        do_reset();
        wr(16'h5300, 4'h0);
        wr(16'h5100, 4'h1);
        check("R6 pin high", gpio_out, 1);
        wr(16'h5300, 4'h1);
        check("R5 pin kept on mode write", gpio_out, 1);
        wr(16'h5100, 4'h1);
        check("R5 pin swapped low", gpio_out, 0);
        wr(16'h5300, 4'h0);
        check("R6 pin stays low", gpio_out, 0);
        wr(16'h5100, 4'h2);
        check("R6 pin from bit0 only", gpio_out, 0);
    endtask

    task automatic t_ignored;
        do_reset();
        wr(16'h5300, 4'h4);
        wr(16'h5000, 4'h5);
        wr(16'h5100, 4'h1);
        wr(16'h5700, 4'hF);
        check("R9 A10 high", prg_hi, 5);
        wr(16'hD000, 4'hF);
        check("R9 romsel low", prg_hi, 5);
        wr(16'h4000, 4'hF);
        wr(16'h4100, 4'h0);
        wr(16'h4200, 4'hF);
        wr(16'h4300, 4'h0);
        check("R9 inert locations bank", prg_hi, 5);
        check("R9 inert locations pin", gpio_out, 1);
        bus_cycle(16'h5000, 4'hF, 1'b1);
        check("R9 read cycle", prg_hi, 5);
        wr(16'h5000, 4'h9);
        check("R2 valid write lands", prg_hi, 9);
    endtask

    task automatic t_reads;
        logic oe, d2;
        do_reset();
        ext_in = 1'b1;
        rd_sample(16'h5100, oe, d2);
        check("R7 oe", oe, 1);
        check("R7 pin high", d2, 1);
        ext_in = 1'b0;
        rd_sample(16'h5500, oe, d2);
        check("R7 A10 ignored oe", oe, 1);
        check("R7 pin low", d2, 0);
        wr(16'h5300, 4'h5);
        ext_in = 1'b1;
        rd_sample(16'h5100, oe, d2);
        check("R7 any mode", d2, 1);
        rd_sample(16'h5000, oe, d2);
        check("R8 other reg", oe, 0);
        rd_sample(16'h4100, oe, d2);
        check("R8 inert reg", oe, 0);
        @(negedge clk);
        put_addr(16'h5100); cpu_rw = 1'b1; m2 = 1'b0;
        @(negedge clk);
        check("R8 m2 low", rd_oe, 0);
        ext_in = 1'b0;
    endtask

    initial begin
        t_reset();
        t_bank_sequence();
        t_full_bits();
        t_pin();
        t_ignored();
        t_reads();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule